// File: doc/BRIEF.md
# Copyback Write-Allocate Data Cache Controller

This block controls a direct-mapped primary data cache that keeps modified lines until they are evicted (copyback) and brings a line in on every miss, stores included (write-allocate). The CPU side issues one load or store at a time. Each request carries a word-aligned address and a data word. The second-level side moves one whole block in a single transfer over a bus as wide as the block. A req/ack handshake and a direction flag govern each transfer.

The controller holds the tag, valid and dirty state for every line. The data array is indexed by the line index alone. A lookup compares the tag and reads the data array in the same cycle. The controller sequences six cases: load hit, store hit, clean load miss, clean store miss, dirty load miss and dirty store miss. A dirty victim is written back in full before the new block is installed. A store miss installs the fetched block first and then merges the CPU word in a separate step. While a request is being looked up, the block address of the request is already on the next-level address lines, so the second level can start its access before the hit result is known.

The CPU holds `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` steady until `cpu_done` is high at a clock edge.

Top module: `cache_copyback_ctrl`

## Requirements
- R1: A load that hits completes in its first cycle: `cpu_done` is high in that cycle, and `cpu_rdata` holds the word chosen by address bits [5:2] of the line chosen by bits [10:6]. Bits [31:11] form the tag, and bits [1:0] are ignored.
- R2: In the first cycle of every request, `nl_addr` equals the request address with bits [5:0] cleared, and `nl_req` is low.
- R3: A store that hits takes two cycles (lookup, then write). It writes only the addressed word, marks the line dirty and makes no next-level transfer.
- R4: A miss on a line that is invalid or clean makes exactly one next-level transfer: a read (`nl_we`=0) of the requested block. No write-back is made.
- R5: A miss on a valid dirty line first makes a write transfer (`nl_we`=1) that carries the whole victim block, addressed by the victim's tag and the line index. A read of the requested block follows directly after the write's ack.
- R6: A store miss installs the fetched block and then writes the CPU word into it in a later cycle. The line ends up dirty, and its other words hold the fetched data.
- R7: A load miss installs the fetched block as clean and returns the requested word from it. Evicting that line later causes no write-back.
- R8: `cpu_stall` is high exactly when `cpu_req` is high and the request does not complete in that cycle.
- R9: After reset every line is invalid and no next-level request is made, so the first access to any line misses.
- R10: Once `nl_req` rises, `nl_req`, `nl_we` and `nl_addr` hold steady until the cycle in which `nl_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Request pending, held until done |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address, word aligned |
| cpu_wdata | input | 32 | Store word |
| cpu_rdata | output | 32 | Load word, valid with cpu_done on a load |
| cpu_done | output | 1 | Request completes this cycle |
| cpu_stall | output | 1 | Request pending and not completing |
| nl_req | output | 1 | Next-level transfer request |
| nl_we | output | 1 | 1 = write-back, 0 = block fetch |
| nl_addr | output | 32 | Block address; the request's block while idle |
| nl_wdata | output | 512 | Victim block for write-back |
| nl_rdata | input | 512 | Fetched block, valid with nl_ack |
| nl_ack | input | 1 | Transfer complete |

## Verification
Two things happen in the same cycle: the tag lookup, and the early presentation of the requested block address to the next level. When the victim is dirty, the address a moment later must switch to the victim's block for the write-back. The bench provokes this with sweeps that store to and load from every line under four tags in turn, so every line passes through the clean, dirty, store-miss and dirty-store-miss cases. In the lookup cycle it compares `nl_addr` with the requested block. It compares the write-back address and data against a shadow copy of memory kept in the bench. Every loaded word is compared against that shadow.

// File: rtl/cc_pkg.sv
package cc_pkg;

  typedef enum logic [2:0] {
    CC_IDLE  = 3'd0,
    CC_WBACK = 3'd1,
    CC_FILL  = 3'd2,
    CC_MERGE = 3'd3,
    CC_RESP  = 3'd4
  } cc_state_e;

endpackage

// File: rtl/cc_tag_store.sv
module cc_tag_store #(
  parameter int LINES = 32,
  parameter int TAG_W = 21,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_valid,
  output logic             rd_dirty,
  input  logic             install_en,
  input  logic [TAG_W-1:0] install_tag,
  input  logic             dirty_en
);

  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] valid_q, valid_d;
  logic [LINES-1:0] dirty_q, dirty_d;

  assign rd_tag   = tag_q[idx];
  assign rd_valid = valid_q[idx];
  assign rd_dirty = dirty_q[idx];

  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    if (install_en) begin
      valid_d[idx] = 1'b1;
      dirty_d[idx] = 1'b0;
    end else if (dirty_en) begin
      dirty_d[idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (install_en) begin
      tag_q[idx] <= install_tag;
    end
  end

  AST_FILL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    install_en |=> valid_q[$past(idx)] && !dirty_q[$past(idx)]); // R7

  AST_MERGE_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_en |=> valid_q[$past(idx)] && dirty_q[$past(idx)]); // R6

endmodule

// File: rtl/cc_data_store.sv
module cc_data_store #(
  parameter int LINES   = 32,
  parameter int WORD_W  = 32,
  parameter int BLOCK_W = 512,
  localparam int IDX_W  = $clog2(LINES),
  localparam int WPB    = BLOCK_W / WORD_W,
  localparam int WSEL_W = $clog2(WPB)
) (
  input  logic               clk,
  input  logic [IDX_W-1:0]   idx,
  output logic [BLOCK_W-1:0] rd_block,
  input  logic               fill_en,
  input  logic [BLOCK_W-1:0] fill_block,
  input  logic               word_en,
  input  logic [WSEL_W-1:0]  word_sel,
  input  logic [WORD_W-1:0]  word_data
);

  for (genvar w = 0; w < WPB; w++) begin : g_bank
    logic [WORD_W-1:0] bank_q [LINES];
    logic              bank_we;
    logic [WORD_W-1:0] bank_d;

    always_comb begin
      bank_we = 1'b0;
      bank_d  = word_data;
      if (fill_en) begin
        bank_we = 1'b1;
        bank_d  = fill_block[w*WORD_W +: WORD_W];
      end else if (word_en && (word_sel == WSEL_W'(w))) begin
        bank_we = 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (bank_we) begin
        bank_q[idx] <= bank_d;
      end
    end

    assign rd_block[w*WORD_W +: WORD_W] = bank_q[idx];
  end

endmodule

// File: rtl/cc_seq.sv
module cc_seq
  import cc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_req,
  input  logic cpu_we,
  input  logic hit,
  input  logic victim_valid,
  input  logic victim_dirty,
  input  logic nl_ack,
  output logic done,
  output logic stall,
  output logic nl_req,
  output logic nl_we,
  output logic fill_en,
  output logic merge_en
);

  cc_state_e st_q, st_d;
  logic      lookup;

  assign lookup = (st_q == CC_IDLE) && cpu_req;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      CC_IDLE: begin
        if (cpu_req) begin
          if (hit) begin
            st_d = cpu_we ? CC_MERGE : CC_IDLE;
          end else if (victim_valid && victim_dirty) begin
            st_d = CC_WBACK;
          end else begin
            st_d = CC_FILL;
          end
        end
      end
      CC_WBACK: if (nl_ack) st_d = CC_FILL;
      CC_FILL:  if (nl_ack) st_d = cpu_we ? CC_MERGE : CC_RESP;
      CC_MERGE: st_d = CC_IDLE;
      CC_RESP:  st_d = CC_IDLE;
      default:  st_d = CC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= CC_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  assign done     = (lookup && hit && !cpu_we) || (st_q == CC_MERGE) || (st_q == CC_RESP);
  assign stall    = cpu_req && !done;
  assign nl_req   = (st_q == CC_WBACK) || (st_q == CC_FILL);
  assign nl_we    = (st_q == CC_WBACK);
  assign fill_en  = (st_q == CC_FILL) && nl_ack;
  assign merge_en = (st_q == CC_MERGE);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    nl_req && !nl_ack |=> nl_req && $stable(nl_we)); // R10

  AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    nl_req && nl_we && nl_ack |=> nl_req && !nl_we); // R5

  AST_CLEAN_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    lookup && !hit && !(victim_valid && victim_dirty) |=> nl_req && !nl_we); // R4

  AST_STORE_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    lookup && hit && cpu_we |=> !nl_req && merge_en); // R3

endmodule

// File: rtl/cache_copyback_ctrl.sv
module cache_copyback_ctrl #(
  parameter int ADDR_W      = 32,
  parameter int WORD_W      = 32,
  parameter int BLOCK_BYTES = 64,
  parameter int LINES       = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cpu_req,
  input  logic                      cpu_we,
  input  logic [ADDR_W-1:0]         cpu_addr,
  input  logic [WORD_W-1:0]         cpu_wdata,
  output logic [WORD_W-1:0]         cpu_rdata,
  output logic                      cpu_done,
  output logic                      cpu_stall,
  output logic                      nl_req,
  output logic                      nl_we,
  output logic [ADDR_W-1:0]         nl_addr,
  output logic [BLOCK_BYTES*8-1:0]  nl_wdata,
  input  logic [BLOCK_BYTES*8-1:0]  nl_rdata,
  input  logic                      nl_ack
);

  localparam int BLOCK_W  = BLOCK_BYTES * 8;
  localparam int OFF_W    = $clog2(BLOCK_BYTES);
  localparam int IDX_W    = $clog2(LINES);
  localparam int TAG_W    = ADDR_W - IDX_W - OFF_W;
  localparam int WPB      = BLOCK_W / WORD_W;
  localparam int WSEL_W   = $clog2(WPB);
  localparam int BYTE_LSB = $clog2(WORD_W / 8);

  logic [TAG_W-1:0]   cpu_tag, rd_tag;
  logic [IDX_W-1:0]   cpu_idx;
  logic [WSEL_W-1:0]  word_sel;
  logic               rd_valid, rd_dirty, hit;
  logic               fill_en, merge_en;
  logic [BLOCK_W-1:0] rd_block;
  logic               unused_low;

  assign cpu_tag    = cpu_addr[ADDR_W-1 -: TAG_W];
  assign cpu_idx    = cpu_addr[OFF_W +: IDX_W];
  assign word_sel   = cpu_addr[BYTE_LSB +: WSEL_W];
  assign unused_low = ^cpu_addr[BYTE_LSB-1:0];
  assign hit        = rd_valid && (rd_tag == cpu_tag);

  cc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) tags_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .idx         (cpu_idx),
    .rd_tag      (rd_tag),
    .rd_valid    (rd_valid),
    .rd_dirty    (rd_dirty),
    .install_en  (fill_en),
    .install_tag (cpu_tag),
    .dirty_en    (merge_en)
  );

  cc_data_store #(.LINES(LINES), .WORD_W(WORD_W), .BLOCK_W(BLOCK_W)) data_i (
    .clk        (clk),
    .idx        (cpu_idx),
    .rd_block   (rd_block),
    .fill_en    (fill_en),
    .fill_block (nl_rdata),
    .word_en    (merge_en),
    .word_sel   (word_sel),
    .word_data  (cpu_wdata)
  );

  cc_seq seq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_req      (cpu_req),
    .cpu_we       (cpu_we),
    .hit          (hit),
    .victim_valid (rd_valid),
    .victim_dirty (rd_dirty),
    .nl_ack       (nl_ack),
    .done         (cpu_done),
    .stall        (cpu_stall),
    .nl_req       (nl_req),
    .nl_we        (nl_we),
    .fill_en      (fill_en),
    .merge_en     (merge_en)
  );

  always_comb begin
    cpu_rdata = rd_block[WORD_W-1:0];
    for (int w = 0; w < WPB; w++) begin
      if (word_sel == WSEL_W'(w)) begin
        cpu_rdata = rd_block[w*WORD_W +: WORD_W];
      end
    end
  end

  assign nl_addr  = {(nl_we ? rd_tag : cpu_tag), cpu_idx, {OFF_W{1'b0}}};
  assign nl_wdata = rd_block;

  AST_NL_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    nl_req && !nl_ack |=> $stable(nl_addr)); // R10

  AST_STALL_XOR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> (cpu_stall != cpu_done)); // R8

  AST_WB_DIRTY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nl_req) && nl_we |-> rd_valid && rd_dirty); // R5

endmodule

// File: tb/cache_copyback_ctrl_tb_top.sv
module cache_copyback_ctrl_tb_top;

  localparam int NBLK = 128;

  logic         clk;
  logic         rst_n;
  logic         cpu_req, cpu_we;
  logic [31:0]  cpu_addr, cpu_wdata, cpu_rdata;
  logic         cpu_done, cpu_stall;
  logic         nl_req, nl_we, nl_ack;
  logic [31:0]  nl_addr;
  logic [511:0] nl_wdata, nl_rdata;

  cache_copyback_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_done(cpu_done), .cpu_stall(cpu_stall),
    .nl_req(nl_req), .nl_we(nl_we), .nl_addr(nl_addr), .nl_wdata(nl_wdata),
    .nl_rdata(nl_rdata), .nl_ack(nl_ack)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic [511:0] back_mem [NBLK];
  logic [511:0] shadow   [NBLK];
  logic         ref_valid [32];
  logic         ref_dirty [32];
  logic [1:0]   ref_tag   [32];

  int          wb_cnt, fill_cnt;
  logic [31:0] last_wb_addr, last_fill_addr;

  task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] init_block(input int blk);
    logic [511:0] b;
    for (int w = 0; w < 16; w++) begin
      b[w*32 +: 32] = 32'hC0DE0000 ^ (blk << 8) ^ w ^ (blk * 32'h01010101);
    end
    return b;
  endfunction

  // Next-level memory: 5-cycle delay before ack
  initial begin
    nl_ack = 1'b0;
    nl_rdata = '0;
    forever begin
      @(negedge clk); #1;
      if (rst_n && nl_req) begin
        automatic logic        we  = nl_we;
        automatic logic [31:0] a   = nl_addr;
        automatic logic [511:0] d  = nl_wdata;
        automatic int          blk = {a[12:11], a[10:6]};
        repeat (4) @(negedge clk);
        #1;
        if (we) begin
          wb_cnt++;
          last_wb_addr = a;
          chk(d == shadow[blk], "R5 write-back data", d, shadow[blk]);
          back_mem[blk] = d;
        end else begin
          fill_cnt++;
          last_fill_addr = a;
          nl_rdata = back_mem[blk];
        end
        nl_ack = 1'b1;
        @(negedge clk); #1;
        nl_ack = 1'b0;
      end
    end
  end

  task automatic do_op(input bit we, input int tag, input int idx, input int ws, input logic [31:0] wd);
    automatic int blk = tag * 32 + idx;
    automatic bit hit = ref_valid[idx] && (ref_tag[idx] == tag[1:0]);
    automatic bit exp_wb = !hit && ref_valid[idx] && ref_dirty[idx];
    automatic logic [31:0] victim = {19'd0, ref_tag[idx], idx[4:0], 6'd0};
    automatic logic [31:0] blk_addr = {19'd0, tag[1:0], idx[4:0], 6'd0};
    automatic int cyc = 0;
    @(negedge clk);
    wb_cnt = 0;
    fill_cnt = 0;
    cpu_req = 1'b1;
    cpu_we = we;
    cpu_addr = blk_addr | (ws << 2) | 32'(we ? 2 : 1);
    cpu_wdata = wd;
    #2;
    chk(nl_addr == blk_addr && !nl_req, "R2 early address", {nl_req, nl_addr}, {1'b0, blk_addr});
    while (!cpu_done && cyc < 40) begin
      chk(cpu_stall == 1'b1, "R8 stall while pending", cpu_stall, 1);
      @(negedge clk); #2;
      cyc++;
    end
    chk(cpu_done && !cpu_stall, "R8 done without stall", {cpu_done, cpu_stall}, 2'b10);
    if (!we) begin
      chk(cpu_rdata == shadow[blk][ws*32 +: 32], hit ? "R1 load hit data" : "R7 load miss data",
          cpu_rdata, shadow[blk][ws*32 +: 32]);
    end
    if (hit && !we) chk(cyc == 0, "R1 load hit in one cycle", cyc, 0);
    if (hit && we)  chk(cyc == 1, "R3 store hit in two cycles", cyc, 1);
    @(posedge clk); #1;
    cpu_req = 1'b0;
    chk(wb_cnt == (exp_wb ? 1 : 0), exp_wb ? "R5 one write-back" : "R4 no write-back", wb_cnt, exp_wb);
    chk(fill_cnt == (hit ? 0 : 1), hit ? "R3 no fetch on hit" : "R4 one fetch on miss", fill_cnt, !hit);
    if (exp_wb) chk(last_wb_addr == victim, "R5 victim address", last_wb_addr, victim);
    if (!hit)   chk(last_fill_addr == blk_addr, "R4 fetch address", last_fill_addr, blk_addr);
    if (we) shadow[blk][ws*32 +: 32] = wd;
    ref_valid[idx] = 1'b1;
    ref_tag[idx] = tag[1:0];
    ref_dirty[idx] = hit ? (ref_dirty[idx] | we) : we;
  endtask

  initial begin
    for (int b = 0; b < NBLK; b++) begin
      back_mem[b] = init_block(b);
      shadow[b] = back_mem[b];
    end
    for (int i = 0; i < 32; i++) begin
      ref_valid[i] = 1'b0;
      ref_dirty[i] = 1'b0;
      ref_tag[i] = 2'd0;
    end
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    wb_cnt = 0; fill_cnt = 0; last_wb_addr = '0; last_fill_addr = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(!nl_req && !cpu_stall && !cpu_done, "R9 quiet in reset", {nl_req, cpu_stall, cpu_done}, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!nl_req && !cpu_stall, "R9 idle after reset", {nl_req, cpu_stall}, 0);

    // R9, R4, R7: first touch of every line is a clean miss
    for (int i = 0; i < 32; i++) do_op(1'b0, 0, i, i % 16, 0);
    // R1: every word of every line hits
    for (int i = 0; i < 32; i++)
      for (int w = 0; w < 16; w++) do_op(1'b0, 0, i, w, 0);
    // R3: store hits
    for (int i = 0; i < 32; i++) do_op(1'b1, 0, i, (i * 3) % 16, 32'h51000000 + i);
    // R5: dirty load misses
    for (int i = 0; i < 32; i++) do_op(1'b0, 1, i, (i * 7) % 16, 0);
    // R6, R4: clean store misses
    for (int i = 0; i < 32; i++) do_op(1'b1, 2, i, (i * 5) % 16, 32'h62000000 + i);
    // R6: other words of store-allocated lines keep fetched data
    for (int i = 0; i < 32; i++) do_op(1'b0, 2, i, (i * 5 + 1) % 16, 0);
    // R5, R6: dirty store misses
    for (int i = 0; i < 32; i++) do_op(1'b1, 3, i, (i * 11) % 16, 32'h73000000 + i);
    // R5: reload earlier blocks, forcing write-back of merged lines
    for (int i = 0; i < 32; i++) do_op(1'b0, 2, i, (i * 5) % 16, 0);
    // R7: clean line evicted without write-back
    for (int i = 0; i < 32; i++) do_op(1'b0, 0, i, (i * 3) % 16, 0);
    // mixed pattern
    for (int i = 0; i < 300; i++)
      do_op((i % 3) == 0, (i * 7) % 4, (i * 13) % 32, (i * 5) % 16, 32'h84000000 ^ i);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule